// File: doc/BRIEF.md
# Workload-Driven Temperature Predictor

This block estimates a core's temperature without a physical sensor, using only how busy the core has been. Each clock cycle it watches the grant lines the core issues to its four mesh neighbours and a strobe that fires when the core accepts a packet from its own main input stream. Every asserted grant bit and every acceptance counts as one unit of work. The block sums these units in a tracker over a fixed prediction window, and a countdown watchdog sets the length of that window.

When the watchdog runs out, the window's event total moves the predicted temperature. A busy window raises the prediction by its event count, and the result saturates at the top of the 8-bit range. A window with no events at all lets the core cool by one degree, but never below an ambient floor. The tracker then clears and the watchdog reloads, so the next window starts from zero. A registered flag reports whether the current prediction is above the overheat threshold. Neighbouring logic reads the prediction and the flag to decide whether to move work away from this core.

Top module: `workload_temp_predictor`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, and right after it, the prediction equals the ambient value 40 and the overheat flag is 0.
- R2: Each asserted bit of the 4-bit neighbour grant input and the acceptance strobe counts as one event in that cycle, so simultaneous events all count (up to 5 per cycle).
- R3: A window is WINDOW clock cycles long. The first window starts on the first rising edge with reset released. At the edge that ends a window with a nonzero event total N, the prediction becomes the old prediction plus N.
- R4: A rise that would pass 255 leaves the prediction at 255.
- R5: A window that ends with zero events lowers the prediction by 1. If the prediction is already 40, it stays at 40.
- R6: The overheat flag is 1 exactly when the prediction is strictly greater than 90. At 90 the flag is 0 and at 91 it is 1, and the flag always matches the prediction it sits next to.
- R7: The prediction and the flag change only at window-ending edges. Events from one window never carry into the next.
- R8: The watchdog reloads at every window end, whatever the activity, so windows follow back to back at a constant length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nb_grant | input | 4 | Grants issued to the four neighbours, one bit each |
| local_accept | input | 1 | Main-stream packet accepted this cycle |
| pred_temp | output | 8 | Predicted temperature |
| over_hot | output | 1 | Prediction is above the overheat threshold |

## Verification
The bench drives whole windows with different mixes of activity. These include idle windows at the floor and above it, single grant bits, several grant bits together with the acceptance strobe, acceptance alone, and fully loaded windows. Together they separate per-bit counting from per-cycle counting and show whether the rise equals the exact event total. Sequences are chosen so the prediction lands exactly on 90 and 91 and so repeated heavy windows reach saturation. At every non-boundary cycle the bench also checks that the outputs have not moved, which catches updates at the wrong edge or a wrong window length.

// File: rtl/tp_pkg.sv
// Package: shared types for the workload temperature predictor.
// Assumes: nothing beyond IEEE 1800-2017.
package tp_pkg;
    // Kind of update applied to the prediction at a window end.
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_RISE = 2'd1,
        UPD_COOL = 2'd2
    } upd_kind_t;
endpackage

// File: rtl/tp_watchdog.sv
// Module: tp_watchdog
// Counts down a prediction window of WINDOW cycles and pulses expire
// (combinationally) in the last cycle of each window, then reloads.
// Assumes: WINDOW >= 2.
module tp_watchdog #(
    parameter int WINDOW = 16,
    localparam int WD_W = $clog2(WINDOW)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            expire,
    output logic [WD_W-1:0] wd_cnt
);
    localparam logic [WD_W-1:0] RELOAD = WD_W'(WINDOW - 1);

    // Window end is the cycle in which the count reaches zero.
    always_comb begin
        expire = (wd_cnt == '0);
    end

    // Down-counter, reloaded by reset and at every window end.
    always_ff @(posedge clk) begin
        if (!rst_n || expire) begin
            wd_cnt <= RELOAD;
        end else begin
            wd_cnt <= wd_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tp_tracker.sv
// Module: tp_tracker
// Counts grant and acceptance events inside the current window. win_total
// includes the current cycle's events, so at a window end it holds the full
// window total; the accumulator clears at that edge.
// Assumes: CNT_W wide enough for WINDOW*(NB+1).
module tp_tracker #(
    parameter int NB    = 4,
    parameter int CNT_W = 7,
    localparam int EV_W = $clog2(NB + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    nb_grant,
    input  logic             local_accept,
    input  logic             expire,
    output logic [CNT_W-1:0] win_total
);
    logic [EV_W-1:0]  ev_now;
    logic [CNT_W-1:0] acc;

    // Number of events presented this cycle.
    always_comb begin
        ev_now = EV_W'(local_accept);
        for (int i = 0; i < NB; i++) begin
            ev_now = ev_now + EV_W'(nb_grant[i]);
        end
    end

    // Window total seen by the update logic.
    always_comb begin
        win_total = acc + CNT_W'(ev_now);
    end

    // Accumulator: cleared by reset and at every window end.
    always_ff @(posedge clk) begin
        if (!rst_n || expire) begin
            acc <= '0;
        end else begin
            acc <= win_total;
        end
    end
endmodule

// File: rtl/tp_temp_update.sv
// Module: tp_temp_update
// Holds the predicted temperature and the overheat flag. At a window end it
// adds the window total (saturating) or cools by one toward ambient.
// Assumes: AMBIENT < 2**TEMP_W, HOT_LIMIT < 2**TEMP_W.
module tp_temp_update
    import tp_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int CNT_W     = 7,
    parameter int AMBIENT   = 40,
    parameter int HOT_LIMIT = 90,
    localparam int SUM_W = ((CNT_W > TEMP_W) ? CNT_W : TEMP_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic [CNT_W-1:0]  win_total,
    output logic [TEMP_W-1:0] pred_temp,
    output logic              over_hot
);
    localparam logic [TEMP_W-1:0] AMB_T  = TEMP_W'(AMBIENT);
    localparam logic [TEMP_W-1:0] HOT_T  = TEMP_W'(HOT_LIMIT);
    localparam logic [SUM_W-1:0]  TOP_S  = SUM_W'((1 << TEMP_W) - 1);

    upd_kind_t         kind;
    logic [SUM_W-1:0]  sum;
    logic [TEMP_W-1:0] temp_nxt;

    // Pick the update kind for this cycle.
    always_comb begin
        if (!expire) begin
            kind = UPD_HOLD;
        end else if (win_total != '0) begin
            kind = UPD_RISE;
        end else begin
            kind = UPD_COOL;
        end
    end

    // Compute the next prediction with saturation and ambient floor.
    always_comb begin
        sum = SUM_W'(pred_temp) + SUM_W'(win_total);
        unique case (kind)
            UPD_RISE: temp_nxt = (sum > TOP_S) ? TOP_S[TEMP_W-1:0] : sum[TEMP_W-1:0];
            UPD_COOL: temp_nxt = (pred_temp > AMB_T) ? pred_temp - 1'b1 : AMB_T;
            default:  temp_nxt = pred_temp;
        endcase
    end

    // Prediction and flag registers, flag derived from the new prediction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_temp <= AMB_T;
            over_hot  <= 1'b0;
        end else begin
            pred_temp <= temp_nxt;
            over_hot  <= (temp_nxt > HOT_T);
        end
    end
endmodule

// File: rtl/workload_temp_predictor.sv
// Module: workload_temp_predictor (top)
// Infers core temperature from neighbour grants and local acceptances
// counted over watchdog-timed windows.
// Assumes: WINDOW >= 2; inputs synchronous to clk.
module workload_temp_predictor #(
    parameter int NB        = 4,
    parameter int TEMP_W    = 8,
    parameter int WINDOW    = 16,
    parameter int AMBIENT   = 40,
    parameter int HOT_LIMIT = 90,
    localparam int CNT_W = $clog2(WINDOW * (NB + 1) + 1),
    localparam int WD_W  = $clog2(WINDOW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     nb_grant,
    input  logic              local_accept,
    output logic [TEMP_W-1:0] pred_temp,
    output logic              over_hot
);
    logic             expire;
    logic [WD_W-1:0]  wd_cnt;
    logic [CNT_W-1:0] win_total;

    tp_watchdog #(.WINDOW(WINDOW)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .wd_cnt (wd_cnt)
    );

    tp_tracker #(.NB(NB), .CNT_W(CNT_W)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .nb_grant     (nb_grant),
        .local_accept (local_accept),
        .expire       (expire),
        .win_total    (win_total)
    );

    tp_temp_update #(
        .TEMP_W    (TEMP_W),
        .CNT_W     (CNT_W),
        .AMBIENT   (AMBIENT),
        .HOT_LIMIT (HOT_LIMIT)
    ) u_upd (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .win_total (win_total),
        .pred_temp (pred_temp),
        .over_hot  (over_hot)
    );
endmodule

// File: rtl/tp_checker.sv
// Module: tp_checker
// Temporal checks on the predictor, bound into the top module.
// Assumes: bound with the top's parameters.
module tp_checker #(
    parameter int TEMP_W    = 8,
    parameter int WINDOW    = 16,
    parameter int AMBIENT   = 40,
    parameter int HOT_LIMIT = 90,
    parameter int CNT_W     = 7,
    parameter int WD_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              expire,
    input logic [WD_W-1:0]   wd_cnt,
    input logic [CNT_W-1:0]  win_total,
    input logic [TEMP_W-1:0] pred_temp,
    input logic              over_hot
);
    localparam logic [TEMP_W-1:0] AMB_T = TEMP_W'(AMBIENT);
    localparam logic [TEMP_W-1:0] HOT_T = TEMP_W'(HOT_LIMIT);
    localparam logic [TEMP_W-1:0] TOP_T = '1;

    // R5: never below ambient
    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pred_temp >= AMB_T);

    // R6: flag tracks prediction
    p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        over_hot == (pred_temp > HOT_T));

    // R7: no change away from a window end
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> $stable(pred_temp));

    // R3: busy window below the top rises
    p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && win_total != '0 && pred_temp != TOP_T) |=> (pred_temp > $past(pred_temp)));

    // R5: idle window above ambient cools by one
    p_cool_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && win_total == '0 && pred_temp > AMB_T) |=> (pred_temp == $past(pred_temp) - 1'b1));

    // R8: watchdog reloads after each window end
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (wd_cnt == WD_W'(WINDOW - 1)));
endmodule

bind workload_temp_predictor tp_checker #(
    .TEMP_W    (TEMP_W),
    .WINDOW    (WINDOW),
    .AMBIENT   (AMBIENT),
    .HOT_LIMIT (HOT_LIMIT),
    .CNT_W     (CNT_W),
    .WD_W      (WD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .wd_cnt    (wd_cnt),
    .win_total (win_total),
    .pred_temp (pred_temp),
    .over_hot  (over_hot)
);

// File: tb/sim_workload_temp_predictor.sv
// Scoreboard bench: the driver pushes the expected prediction per window,
// the monitor pops and compares at each window end.
module sim_workload_temp_predictor;
    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nb_grant = '0;
    logic       local_accept = 1'b0;
    logic [7:0] pred_temp;
    logic       over_hot;

    int errors = 0;
    int checks = 0;
    int model_t = 40;
    int last_t = 40;
    logic last_f = 1'b0;
    int exp_q[$];

    always #2 clk = ~clk;

    workload_temp_predictor #(.WINDOW(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .nb_grant     (nb_grant),
        .local_accept (local_accept),
        .pred_temp    (pred_temp),
        .over_hot     (over_hot)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Set one cycle's inputs, then wait to the next falling edge.
    task automatic drive_cycle(input logic [3:0] g, input logic a);
        nb_grant = g;
        local_accept = a;
        @(negedge clk);
    endtask

    // One window: `active` cycles of (g,a), rest idle. Pushes the expectation first.
    task automatic run_window(input logic [3:0] g, input logic a, input int active);
        int total;
        total = active * ($countones(g) + int'(a));
        if (total == 0) begin
            if (model_t > 40) model_t--;
        end else begin
            model_t = model_t + total;
            if (model_t > 255) model_t = 255;
        end
        exp_q.push_back(model_t);
        for (int c = 0; c < W; c++) begin
            if (c < active) drive_cycle(g, a);
            else drive_cycle(4'b0000, 1'b0);
        end
    endtask

    // Monitor: window-end compare (R3..R6) and mid-window stability (R7).
    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            if (rst_n) begin
                cyc++;
                @(negedge clk);
                if (cyc % W == 0) begin
                    if (exp_q.size() > 0) begin
                        int e;
                        e = exp_q.pop_front();
                        check("R3/R4/R5 prediction", int'(pred_temp), e);
                        check("R6 flag", int'(over_hot), int'(e > 90));
                        last_t = e;
                        last_f = (e > 90);
                    end
                end else begin
                    check("R7/R8 stable mid-window", int'(pred_temp), last_t);
                    check("R7 flag stable", int'(over_hot), int'(last_f));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset temp", int'(pred_temp), 40);
        check("R1 reset flag", int'(over_hot), 0);
        rst_n = 1'b1;
        run_window(4'b0000, 1'b0, 0);   // R5 floor: stays 40
        run_window(4'b0001, 1'b0, 8);   // R2 single bit: 48
        run_window(4'b1010, 1'b1, 4);   // R2 mixed: +12 -> 60
        run_window(4'b1111, 1'b1, 5);   // R2 all: +25 -> 85
        run_window(4'b0000, 1'b1, 5);   // R3 accept only: 90, flag 0 (R6)
        run_window(4'b0100, 1'b0, 1);   // R6: 91, flag 1
        run_window(4'b0000, 1'b0, 0);   // R5/R6: 90, flag 0
        run_window(4'b0000, 1'b0, 0);   // R5: 89
        for (int k = 0; k < 5; k++) run_window(4'b1111, 1'b1, 8); // R4 saturate
        run_window(4'b1111, 1'b1, 1);   // R4 held at 255
        run_window(4'b0000, 1'b0, 0);   // R5: 254
        run_window(4'b0000, 1'b0, 0);   // R5: 253
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule